// File: doc/BRIEF.md
# Stage-Rotated Cell Register File

This block is the local operand store of one processing cell in a coarse-grained reconfigurable array. It keeps a small file of 32-bit data words and a matching file of single-bit predicate flags. The predicate flags hold compare outcomes that later steer data-dependent selection. The cell reads its register addresses from a static configuration context. The block adds a running stage count to each of those addresses before use. A modulo-scheduled loop kernel can therefore replay the same context on every iteration while each iteration's values land in fresh physical entries. Nothing has to be shuffled across the array interconnect.

The stage count is held inside the block. A kernel-start strobe clears it, and an iteration-advance strobe steps it. Five configured address fields pass through the rotation: the data write address, the two data read addresses, the predicate write address and the predicate read address. The data write value comes either from this cell's own result or from a neighbouring cell, chosen by a source select. All read results are registered.

Top module: `stage_rot_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, the stage count becomes 0, every data and predicate entry becomes 0, and all read outputs become 0.
- R2: With `kernel_start` low and `iter_adv` high, the stage count advances by one at the clock edge and wraps from 7 to 0. With both strobes low it holds its value.
- R3: With `kernel_start` high, the stage count becomes 0 at the clock edge, even if `iter_adv` is also high.
- R4: With `d_we` high, the data entry at physical index (`d_waddr` + stage) mod 8 takes the write value at the clock edge. The stage used is the value before that edge, and the carry of the sum is dropped.
- R5: At every clock edge `d_rdata_a` and `d_rdata_b` each load the data entry at physical index (their address + stage) mod 8. Both ports read in the same cycle.
- R6: When a read hits the entry being written at the same edge, the read returns the value held before the write.
- R7: The data write value is `d_wdata_local` when `d_wsrc` is 0 and `d_wdata_nbr` when `d_wsrc` is 1.
- R8: With `p_we` high, predicate entry (`p_waddr` + stage) mod 8 takes `p_wdata` at the clock edge. At every edge `p_rdata` loads predicate entry (`p_raddr` + stage) mod 8.
- R9: With `d_we` low, no data entry changes, whatever the write data and address inputs. With `p_we` low, no predicate entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kernel_start | input | 1 | Clears the stage count |
| iter_adv | input | 1 | Advances the stage count by one |
| stage_o | output | 3 | Current stage count |
| d_we | input | 1 | Data file write enable |
| d_waddr | input | 3 | Configured data write address |
| d_wsrc | input | 1 | Write source: 0 own result, 1 neighbour |
| d_wdata_local | input | 32 | Result from this cell |
| d_wdata_nbr | input | 32 | Result from a neighbouring cell |
| d_raddr_a | input | 3 | Configured data read address, port A |
| d_raddr_b | input | 3 | Configured data read address, port B |
| d_rdata_a | output | 32 | Registered data read, port A |
| d_rdata_b | output | 32 | Registered data read, port B |
| p_we | input | 1 | Predicate write enable |
| p_waddr | input | 3 | Configured predicate write address |
| p_wdata | input | 1 | Predicate value to store |
| p_raddr | input | 3 | Configured predicate read address |
| p_rdata | output | 1 | Registered predicate read |

## Verification
The hard case is a rotation fault: the stage offset is lost, or it is applied to only one side of the file. Such a fault stays invisible while writes and reads share a stage, because the rotations cancel. The stimulus therefore fills the whole file at each of the eight stages, advances the stage once, and sweeps every pair of read addresses. Each logical read then maps to an entry written under a different logical address. Read-during-write, strobe collisions and the 7-to-0 wrap are each driven directly afterwards.

// File: rtl/srf_pkg.sv
package srf_pkg;
  // segment order inside the rotated address vector
  localparam int SEG_DW  = 0;
  localparam int SEG_DRA = 1;
  localparam int SEG_DRB = 2;
  localparam int SEG_PW  = 3;
  localparam int SEG_PR  = 4;
  localparam int NSEG    = 5;

  typedef enum logic {
    SRC_LOCAL = 1'b0,
    SRC_NBR   = 1'b1
  } wsrc_e;
endpackage

// File: rtl/srf_stage_ctr.sv
module srf_stage_ctr #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kernel_start,
  input  logic          iter_adv,
  output logic [SW-1:0] stage
);
  always_ff @(posedge clk) begin
    if (rst || kernel_start) begin
      stage <= '0;
    end else if (iter_adv) begin
      stage <= stage + 1'b1;
    end
  end

  // R2: advance wraps modulo the stage range
  p_stage_step_r2: assert property (@(posedge clk) disable iff (rst)
    (iter_adv && !kernel_start) |=> (stage == SW'($past(stage) + 1'b1)));

  // R2: no strobe, no change
  p_stage_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!iter_adv && !kernel_start) |=> $stable(stage));

  // R3: start wins over advance
  p_stage_start_r3: assert property (@(posedge clk) disable iff (rst)
    kernel_start |=> (stage == '0));
endmodule

// File: rtl/srf_addr_rot.sv
module srf_addr_rot #(
  parameter int AW   = 3,
  parameter int NSEG = 5
) (
  input  logic [AW-1:0]           stage,
  input  logic [NSEG-1:0][AW-1:0] seg_in,
  output logic [NSEG-1:0][AW-1:0] seg_out
);
  // each configured field is offset by the stage; the carry is dropped
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign seg_out[g] = AW'(seg_in[g] + stage);
  end
endmodule

// File: rtl/srf_bank.sv
module srf_bank #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [DW-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][DW-1:0] rdata
);
  logic [DEPTH-1:0][DW-1:0] mem;

  // write port; nonblocking update gives old data to same-edge reads
  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) begin
        rdata[r] <= '0;
      end else begin
        rdata[r] <= mem[raddr[r]];
      end
    end
  end

  // R1: reset leaves storage and outputs cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> ((mem == '0) && (rdata == '0)));

  // R9: no enable, no change to storage
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mem));

  // R4: an enabled write lands in the addressed entry
  p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/stage_rot_regfile.sv
module stage_rot_regfile
  import srf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kernel_start,
  input  logic          iter_adv,
  output logic [AW-1:0] stage_o,
  input  logic          d_we,
  input  logic [AW-1:0] d_waddr,
  input  logic          d_wsrc,
  input  logic [DW-1:0] d_wdata_local,
  input  logic [DW-1:0] d_wdata_nbr,
  input  logic [AW-1:0] d_raddr_a,
  input  logic [AW-1:0] d_raddr_b,
  output logic [DW-1:0] d_rdata_a,
  output logic [DW-1:0] d_rdata_b,
  input  logic          p_we,
  input  logic [AW-1:0] p_waddr,
  input  logic          p_wdata,
  input  logic [AW-1:0] p_raddr,
  output logic          p_rdata
);
  logic [AW-1:0]           stage;
  logic [NSEG-1:0][AW-1:0] cfg_addr;
  logic [NSEG-1:0][AW-1:0] phys_addr;
  logic [DW-1:0]           d_wdata;
  logic [1:0][AW-1:0]      d_rd_addr;
  logic [1:0][DW-1:0]      d_rd_data;
  logic [0:0][AW-1:0]      p_rd_addr;
  logic [0:0][0:0]         p_rd_data;

  srf_stage_ctr #(.SW(AW)) u_stage (
    .clk          (clk),
    .rst          (rst),
    .kernel_start (kernel_start),
    .iter_adv     (iter_adv),
    .stage        (stage)
  );

  assign stage_o = stage;

  always_comb begin
    cfg_addr          = '0;
    cfg_addr[SEG_DW]  = d_waddr;
    cfg_addr[SEG_DRA] = d_raddr_a;
    cfg_addr[SEG_DRB] = d_raddr_b;
    cfg_addr[SEG_PW]  = p_waddr;
    cfg_addr[SEG_PR]  = p_raddr;
  end

  srf_addr_rot #(.AW(AW), .NSEG(NSEG)) u_rot (
    .stage   (stage),
    .seg_in  (cfg_addr),
    .seg_out (phys_addr)
  );

  // write source select: own result or neighbour cell
  always_comb begin
    if (wsrc_e'(d_wsrc) == SRC_NBR) d_wdata = d_wdata_nbr;
    else                            d_wdata = d_wdata_local;
  end

  assign d_rd_addr[0] = phys_addr[SEG_DRA];
  assign d_rd_addr[1] = phys_addr[SEG_DRB];
  assign p_rd_addr[0] = phys_addr[SEG_PR];

  srf_bank #(.DEPTH(DEPTH), .DW(DW), .NRD(2)) u_dfile (
    .clk   (clk),
    .rst   (rst),
    .we    (d_we),
    .waddr (phys_addr[SEG_DW]),
    .wdata (d_wdata),
    .raddr (d_rd_addr),
    .rdata (d_rd_data)
  );

  srf_bank #(.DEPTH(DEPTH), .DW(1), .NRD(1)) u_pfile (
    .clk   (clk),
    .rst   (rst),
    .we    (p_we),
    .waddr (phys_addr[SEG_PW]),
    .wdata (p_wdata),
    .raddr (p_rd_addr),
    .rdata (p_rd_data)
  );

  assign d_rdata_a = d_rd_data[0];
  assign d_rdata_b = d_rd_data[1];
  assign p_rdata   = p_rd_data[0][0];

  // R5: two reads of the same configured address agree
  p_dual_read_r5: assert property (@(posedge clk) disable iff (rst)
    (d_raddr_a == d_raddr_b) |=> (d_rdata_a == d_rdata_b));

  // R1: outputs and stage cleared after reset
  p_reset_out_r1: assert property (@(posedge clk)
    rst |=> ((stage_o == '0) && (d_rdata_a == '0) && (d_rdata_b == '0) && !p_rdata));
endmodule

// File: tb/stage_rot_regfile_tb.sv
module stage_rot_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        kernel_start = 1'b0, iter_adv = 1'b0;
  logic [2:0]  stage_o;
  logic        d_we = 1'b0, d_wsrc = 1'b0;
  logic [2:0]  d_waddr = '0, d_raddr_a = '0, d_raddr_b = '0;
  logic [31:0] d_wdata_local = '0, d_wdata_nbr = '0;
  logic [31:0] d_rdata_a, d_rdata_b;
  logic        p_we = 1'b0, p_wdata = 1'b0, p_rdata;
  logic [2:0]  p_waddr = '0, p_raddr = '0;

  // bench model
  logic [31:0] dm [8];
  logic        pm [8];
  logic [2:0]  ms;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stage_rot_regfile u_dut (
    .clk(clk), .rst(rst), .kernel_start(kernel_start), .iter_adv(iter_adv),
    .stage_o(stage_o), .d_we(d_we), .d_waddr(d_waddr), .d_wsrc(d_wsrc),
    .d_wdata_local(d_wdata_local), .d_wdata_nbr(d_wdata_nbr),
    .d_raddr_a(d_raddr_a), .d_raddr_b(d_raddr_b),
    .d_rdata_a(d_rdata_a), .d_rdata_b(d_rdata_b),
    .p_we(p_we), .p_waddr(p_waddr), .p_wdata(p_wdata),
    .p_raddr(p_raddr), .p_rdata(p_rdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: predict, let the edge pass, compare at the falling edge
  task automatic tick(string trd, string tst);
    logic [31:0] ea, eb;
    logic        ep;
    logic [2:0]  ia, ib, ip, iw, ipw;
    if (rst) begin
      for (int i = 0; i < 8; i++) begin dm[i] = '0; pm[i] = 1'b0; end
      ms = '0; ea = '0; eb = '0; ep = 1'b0;
    end else begin
      ia = d_raddr_a + ms; ib = d_raddr_b + ms; ip = p_raddr + ms;
      ea = dm[ia]; eb = dm[ib]; ep = pm[ip];
      iw = d_waddr + ms; ipw = p_waddr + ms;
      if (d_we) dm[iw] = d_wsrc ? d_wdata_nbr : d_wdata_local;
      if (p_we) pm[ipw] = p_wdata;
      if (kernel_start) ms = '0;
      else if (iter_adv) ms = ms + 3'd1;
    end
    @(posedge clk);
    @(negedge clk);
    chk({trd, " data A"}, d_rdata_a, ea);
    chk({trd, " data B"}, d_rdata_b, eb);
    chk("R8 predicate", {31'd0, p_rdata}, {31'd0, ep});
    chk({tst, " stage"}, {29'd0, stage_o}, {29'd0, ms});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset
    tick("R1", "R1");
    tick("R1", "R1");
    rst = 1'b0;
    for (int a = 0; a < 8; a++) begin
      d_raddr_a = 3'(a); d_raddr_b = 3'(7 - a); p_raddr = 3'(a);
      tick("R1", "R2");
    end

    // R4 R5 R7 R8: fill at each stage, read everything one stage later
    for (int s = 0; s < 8; s++) begin
      kernel_start = 1'b1; tick("R5", "R3"); kernel_start = 1'b0;
      iter_adv = 1'b1;
      for (int k = 0; k < s; k++) tick("R5", "R2");
      iter_adv = 1'b0;
      d_we = 1'b1; p_we = 1'b1;
      for (int a = 0; a < 8; a++) begin
        d_waddr = 3'(a); p_waddr = 3'(a);
        d_wdata_local = 32'hC3000000 ^ (s << 12) ^ (a << 4) ^ a;
        d_wdata_nbr   = ~d_wdata_local;
        d_wsrc  = a[0] ^ s[1];
        p_wdata = a[0] ^ a[2] ^ s[0];
        tick("R4 R7", "R2");
      end
      d_we = 1'b0; p_we = 1'b0;
      iter_adv = 1'b1; tick("R5", "R2"); iter_adv = 1'b0;
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          d_raddr_a = 3'(a); d_raddr_b = 3'(b); p_raddr = 3'(a ^ b);
          tick("R4 R5 R7", "R2");
        end
      end
    end

    // R6: read of the entry being written returns the old value
    d_we = 1'b1; d_wsrc = 1'b0; d_waddr = 3'd3; d_wdata_local = 32'h5EED0006;
    d_raddr_a = 3'd3; d_raddr_b = 3'd3;
    p_we = 1'b1; p_waddr = 3'd5; p_raddr = 3'd5; p_wdata = ~pm[3'(5 + ms)];
    tick("R6", "R2");
    d_we = 1'b0; p_we = 1'b0;
    tick("R6 R4", "R2");

    // R9: disabled writes leave contents untouched
    d_waddr = 3'd3; d_wdata_local = 32'hBADBAD09; d_wdata_nbr = 32'hBADBAD90;
    p_waddr = 3'd5; p_wdata = ~p_wdata;
    tick("R9", "R2");
    d_raddr_a = 3'd3; d_raddr_b = 3'd4;
    tick("R9", "R2");

    // R3: start beats advance
    iter_adv = 1'b1; kernel_start = 1'b1;
    tick("R5", "R3");
    kernel_start = 1'b0;
    // R2: wrap 7 -> 0
    for (int k = 0; k < 9; k++) tick("R5", "R2");
    iter_adv = 1'b0;
    tick("R5", "R2");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule